// File: doc/BRIEF.md
# Serial Port Bit-Rate Tick Generator

This block produces the bit-rate enables for the transmitter and the receiver of a small four-mode serial port. Two of the modes run at fixed fractions of the system clock. The other two derive their rate from overflow pulses of two external timers. The transmitter and the receiver each choose their own timer, so the two directions can run at different rates.

All outputs are single-cycle enables in the system clock domain. No clocks are derived. A shared fixed-ratio counter serves the fixed-rate modes. Each direction has its own event counter, which divides the chosen timer's overflow pulses down to one bit tick. The framing logic consumes the ticks, and the timers that produce the overflow pulses lie outside this block.

Reset is synchronous and active low. A change of mode clears every counter so that the new mode starts from a clean phase.

Top module: `baud_tick_sel`

## Requirements
- R1: With `mode_i` = 2'b00 (shift-register mode), both ticks pulse once for every 12 clock edges. Counting starts at the first edge after reset or after a mode change. The first tick is high in the cycle after the 12th counted edge.
- R2: With `mode_i` = 2'b10 (fixed-rate 9-bit mode), both ticks pulse once every 64 edges when `dbl_i` = 0 and once every 32 edges when `dbl_i` = 1.
- R3: With `mode_i[0]` = 1 (modes 2'b01 and 2'b11), the transmit tick counts `t2_ovf_i` pulses when `tx_t2_sel_i` = 1 and `t1_ovf_i` pulses when it is 0.
- R4: In the same modes, the receive tick counts `t2_ovf_i` pulses when `rx_t2_sel_i` = 1 and `t1_ovf_i` pulses when it is 0, regardless of the transmit selection.
- R5: A direction fed from timer 2 ticks once every 16 of its pulses whatever `dbl_i` is. A direction fed from timer 1 ticks once every 32 pulses when `dbl_i` = 0 and once every 16 when `dbl_i` = 1. The tick is high in the cycle after the edge that saw the last pulse.
- R6: Each tick is high for exactly one clock cycle, and the cycle after a tick is never a tick.
- R7: On any edge where `mode_i` differs from its value at the previous edge, every counter clears and that edge's pulses are not counted. Both ticks are low in the following cycle.
- R8: While `rst_n` is low, every counter clears. Both ticks are low in the cycle after any reset edge.
- R9: When the previous edge was in a fixed-rate mode (`mode_i[0]` = 0), `tx_tick_o` equals `rx_tick_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| mode_i | input | 2 | Serial port mode: 00 shift, 01 timed 8-bit, 10 fixed 9-bit, 11 timed 9-bit |
| dbl_i | input | 1 | Rate doubling select |
| tx_t2_sel_i | input | 1 | Transmit source: 1 = timer 2 overflow, 0 = timer 1 overflow |
| rx_t2_sel_i | input | 1 | Receive source: 1 = timer 2 overflow, 0 = timer 1 overflow |
| t1_ovf_i | input | 1 | Timer 1 overflow pulse, one cycle wide |
| t2_ovf_i | input | 1 | Timer 2 overflow pulse, one cycle wide |
| tx_tick_o | output | 1 | Transmit bit-rate enable |
| rx_tick_o | output | 1 | Receive bit-rate enable |

## Verification
Two events can fall on the same edge: a mode change and an overflow pulse that would otherwise complete a divide. The clear must win. The mode-change run switches modes every 37 cycles while timer 1 pulses on every cycle and timer 2 on every other cycle, so switches land on counted pulses and near wrap points. An arithmetic reference restarts at the switch, and the bench compares every cycle's ticks against it.

A second coincidence is both directions counting the same timer pulse. The sweep pattern that fires both timers together checks that the two ticks coincide exactly when the model predicts it.

// File: rtl/baud_sel_pkg.sv
// Package: shared types and helpers for the serial bit-rate tick generator.
// Assumes mode bit 0 set means the rate comes from timer overflows.
package baud_sel_pkg;

    // Serial port operating modes, in the order of their two-bit code.
    typedef enum logic [1:0] {
        SP_SHIFT  = 2'b00,
        SP_TIMED8 = 2'b01,
        SP_FIXED9 = 2'b10,
        SP_TIMED9 = 2'b11
    } sp_mode_e;

    // Transmit and receive lanes.
    localparam int unsigned LANE_TX = 0;
    localparam int unsigned LANE_RX = 1;
    localparam int unsigned LANES   = 2;

    // True when the mode takes its rate from timer overflow pulses.
    function automatic logic sp_is_timed(input logic [1:0] mode);
        return mode[0];
    endfunction

    // Larger of two unsigned values, used for counter sizing.
    function automatic int unsigned umax(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/baud_cnt.sv
// Module: modulo event counter that emits a one-cycle tick on wrap.
// Counts ev pulses. When the count reaches lim-1 on an event it wraps to
// zero and raises tick for the next cycle. Assumes lim is at least 2.
// A synchronous clear or reset forces the count and tick to zero.
module baud_cnt #(
    parameter int unsigned CW = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          ev,
    input  logic [CW-1:0] lim,
    output logic          tick
);

    logic [CW-1:0] cnt_q;
    logic          wrap;

    // Wrap when the current count is the last step of the division
    // (>= keeps it safe if lim shrinks mid-count).
    assign wrap = (cnt_q >= (lim - CW'(1)));

    // Advance the count on each event and register the wrap tick.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt_q <= '0;
            tick  <= 1'b0;
        end else if (ev) begin
            if (wrap) begin
                cnt_q <= '0;
                tick  <= 1'b1;
            end else begin
                cnt_q <= cnt_q + CW'(1);
                tick  <= 1'b0;
            end
        end else begin
            tick <= 1'b0;
        end
    end

endmodule

// File: rtl/baud_fixed.sv
// Module: fixed-ratio divider for the two modes clocked from the system clock.
// Counts every enabled clock. Shift mode uses SHIFT_DIV; the fixed 9-bit
// mode uses SLOW_DIV or, with doubling, FAST_DIV.
// Assumes the enable is low in the timed modes.
module baud_fixed #(
    parameter int unsigned CW        = 7,
    parameter int unsigned SHIFT_DIV = 12,
    parameter int unsigned SLOW_DIV  = 64,
    parameter int unsigned FAST_DIV  = 32
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr,
    input  logic       en,
    input  logic [1:0] mode,
    input  logic       dbl,
    output logic       tick
);
    import baud_sel_pkg::*;

    logic [CW-1:0] lim;

    // Pick the division ratio from the current mode and doubling bit.
    always_comb begin
        if (mode == SP_FIXED9) begin
            lim = dbl ? CW'(FAST_DIV) : CW'(SLOW_DIV);
        end else begin
            lim = CW'(SHIFT_DIV);
        end
    end

    baud_cnt #(.CW(CW)) u_cnt (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (clr),
        .ev   (en),
        .lim  (lim),
        .tick (tick)
    );

endmodule

// File: rtl/baud_lane.sv
// Module: one direction's timed-mode divider.
// Selects timer 1 or timer 2 overflow pulses. Timer 2 pulses are always
// divided by FAST_DIV. Timer 1 pulses are divided by SLOW_DIV, or by
// FAST_DIV when doubling is set. Assumes overflow inputs are one cycle wide.
module baud_lane #(
    parameter int unsigned CW       = 7,
    parameter int unsigned SLOW_DIV = 32,
    parameter int unsigned FAST_DIV = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic en,
    input  logic t2_sel,
    input  logic dbl,
    input  logic t1_ovf,
    input  logic t2_ovf,
    output logic tick
);

    logic          src_ev;
    logic [CW-1:0] lim;

    // Route the chosen timer's overflow into the counter, gated by mode.
    always_comb begin
        src_ev = en & (t2_sel ? t2_ovf : t1_ovf);
    end

    // Pick the divide ratio; doubling applies only to the timer 1 source.
    always_comb begin
        if (t2_sel || dbl) begin
            lim = CW'(FAST_DIV);
        end else begin
            lim = CW'(SLOW_DIV);
        end
    end

    baud_cnt #(.CW(CW)) u_cnt (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (clr),
        .ev   (src_ev),
        .lim  (lim),
        .tick (tick)
    );

endmodule

// File: rtl/baud_tick_sel.sv
// Module: serial port bit-rate tick generator (top).
// Fixed-rate modes share one system-clock divider. Timed modes run one
// overflow divider per direction with an independent source choice.
// A change in mode clears all counters. Outputs follow the mode seen at
// the previous edge, so each output is a registered tick.
// Assumes all inputs are synchronous to clk.
module baud_tick_sel #(
    parameter int unsigned SHIFT_DIV    = 12,
    parameter int unsigned FIX_SLOW_DIV = 64,
    parameter int unsigned FIX_FAST_DIV = 32,
    parameter int unsigned OVF_SLOW_DIV = 32,
    parameter int unsigned OVF_FAST_DIV = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] mode_i,
    input  logic       dbl_i,
    input  logic       tx_t2_sel_i,
    input  logic       rx_t2_sel_i,
    input  logic       t1_ovf_i,
    input  logic       t2_ovf_i,
    output logic       tx_tick_o,
    output logic       rx_tick_o
);
    import baud_sel_pkg::*;

    localparam int unsigned MAX_DIV = umax(umax(SHIFT_DIV, FIX_SLOW_DIV),
                                           umax(FIX_FAST_DIV, umax(OVF_SLOW_DIV, OVF_FAST_DIV)));
    localparam int unsigned CW      = $clog2(MAX_DIV) + 1;

    sp_mode_e           mode_q;
    logic               mode_chg;
    logic               timed_now;
    logic               fix_tick;
    logic [LANES-1:0]   lane_sel;
    logic [LANES-1:0]   lane_tick;

    // Remember the mode of the previous edge for change detection and output muxing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= sp_mode_e'(mode_i);
        end else begin
            mode_q <= sp_mode_e'(mode_i);
        end
    end

    // Flag a mode change and classify the current mode.
    always_comb begin
        mode_chg  = (mode_i != mode_q);
        timed_now = sp_is_timed(mode_i);
    end

    // Gather per-lane source selects in lane order.
    always_comb begin
        lane_sel[LANE_TX] = tx_t2_sel_i;
        lane_sel[LANE_RX] = rx_t2_sel_i;
    end

    baud_fixed #(
        .CW       (CW),
        .SHIFT_DIV(SHIFT_DIV),
        .SLOW_DIV (FIX_SLOW_DIV),
        .FAST_DIV (FIX_FAST_DIV)
    ) u_fixed (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (mode_chg),
        .en   (~timed_now),
        .mode (mode_i),
        .dbl  (dbl_i),
        .tick (fix_tick)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        baud_lane #(
            .CW      (CW),
            .SLOW_DIV(OVF_SLOW_DIV),
            .FAST_DIV(OVF_FAST_DIV)
        ) u_lane (
            .clk   (clk),
            .rst_n (rst_n),
            .clr   (mode_chg),
            .en    (timed_now),
            .t2_sel(lane_sel[g]),
            .dbl   (dbl_i),
            .t1_ovf(t1_ovf_i),
            .t2_ovf(t2_ovf_i),
            .tick  (lane_tick[g])
        );
    end

    // Steer each output from the divider that ran on the previous edge.
    always_comb begin
        if (sp_is_timed(mode_q)) begin
            tx_tick_o = lane_tick[LANE_TX];
            rx_tick_o = lane_tick[LANE_RX];
        end else begin
            tx_tick_o = fix_tick;
            rx_tick_o = fix_tick;
        end
    end

endmodule

// File: rtl/baud_tick_sel_chk.sv
// Checker: temporal properties of the bit-rate tick generator, bound to the top.
// Keeps its own copy of the previous mode and a valid flag for the first edge.
module baud_tick_sel_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] mode_i,
    input logic       dbl_i,
    input logic       tx_t2_sel_i,
    input logic       rx_t2_sel_i,
    input logic       t1_ovf_i,
    input logic       t2_ovf_i,
    input logic       tx_tick_o,
    input logic       rx_tick_o
);

    logic       pv = 1'b0;
    logic [1:0] mq = 2'b00;

    // Track edge history for the properties.
    always_ff @(posedge clk) begin
        pv <= 1'b1;
        mq <= mode_i;
    end

    assert_tx_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        tx_tick_o |=> !tx_tick_o);

    assert_rx_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rx_tick_o |=> !rx_tick_o);

    assert_mode_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (pv && (mode_i != mq)) |=> (!tx_tick_o && !rx_tick_o));

    assert_reset_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (pv && $past(!rst_n)) |-> (!tx_tick_o && !rx_tick_o));

    assert_fixed_lockstep_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (pv && !mq[0]) |-> (tx_tick_o == rx_tick_o));

    assert_tx_source_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (pv && mq[0] && tx_tick_o) |-> $past(tx_t2_sel_i ? t2_ovf_i : t1_ovf_i));

    assert_rx_source_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (pv && mq[0] && rx_tick_o) |-> $past(rx_t2_sel_i ? t2_ovf_i : t1_ovf_i));

    // dbl_i is observed only through the tick spacing, which the bench judges.
    logic unused_dbl;
    assign unused_dbl = dbl_i;

endmodule

bind baud_tick_sel baud_tick_sel_chk u_chk (.*);

// File: tb/baud_tick_sel_tb.sv
// Bench: sweeps every mode, doubling, source selection and three pulse
// patterns, then a mode-switching run; compares each cycle to an arithmetic model.
module baud_tick_sel_tb;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [1:0] mode_i;
    logic       dbl_i, tx_t2_sel_i, rx_t2_sel_i, t1_ovf_i, t2_ovf_i;
    logic       tx_tick_o, rx_tick_o;

    int vecs = 0;
    int miss = 0;

    // Reference state
    int         m_cf, m_ctx, m_crx;
    logic [1:0] m_pmode;
    logic       e_tx, e_rx, prev_tx, prev_rx;
    string      tag_tx, tag_rx;
    bit         m_fixed;

    always #(CLK_PERIOD/2) clk = ~clk;

    baud_tick_sel u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode_i     (mode_i),
        .dbl_i      (dbl_i),
        .tx_t2_sel_i(tx_t2_sel_i),
        .rx_t2_sel_i(rx_t2_sel_i),
        .t1_ovf_i   (t1_ovf_i),
        .t2_ovf_i   (t2_ovf_i),
        .tx_tick_o  (tx_tick_o),
        .rx_tick_o  (rx_tick_o)
    );

    task automatic summary();
        $display("  == %0d vectors applied, %0d miscompares ==", vecs, miss);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #(CLK_PERIOD * 190000);
        miss++;
        $display("FAIL watchdog R1 expired: actual=hung expected=done");
        summary();
        $finish;
    end

    task automatic chk(input logic act, input logic exp, input string tag);
        vecs++;
        if (act !== exp) begin
            miss++;
            $display("FAIL %s: actual=%0b expected=%0b (mode=%b dbl=%0b txs=%0b rxs=%0b)",
                     tag, act, exp, mode_i, dbl_i, tx_t2_sel_i, rx_t2_sel_i);
        end
    endtask

    // Advance one modulo counter by one edge.
    task automatic adv(ref int c, input logic ev, input int n, output logic t);
        t = 1'b0;
        if (ev) begin
            if (c >= n - 1) begin
                c = 0;
                t = 1'b1;
            end else begin
                c = c + 1;
            end
        end
    endtask

    // Predict the outputs after the coming edge from the inputs now applied.
    task automatic model_edge();
        int n;
        m_fixed = 1'b0;
        if (!rst_n) begin
            m_cf = 0; m_ctx = 0; m_crx = 0; e_tx = 0; e_rx = 0;
            tag_tx = "R8"; tag_rx = "R8";
        end else if (mode_i != m_pmode) begin
            m_cf = 0; m_ctx = 0; m_crx = 0; e_tx = 0; e_rx = 0;
            tag_tx = "R7"; tag_rx = "R7";
        end else if (!mode_i[0]) begin
            m_fixed = 1'b1;
            n = mode_i[1] ? (dbl_i ? 32 : 64) : 12;
            adv(m_cf, 1'b1, n, e_tx);
            e_rx = e_tx;
            tag_tx = mode_i[1] ? "R2" : "R1";
            tag_rx = tag_tx;
        end else begin
            adv(m_ctx, tx_t2_sel_i ? t2_ovf_i : t1_ovf_i,
                (tx_t2_sel_i || dbl_i) ? 16 : 32, e_tx);
            adv(m_crx, rx_t2_sel_i ? t2_ovf_i : t1_ovf_i,
                (rx_t2_sel_i || dbl_i) ? 16 : 32, e_rx);
            tag_tx = (!tx_t2_sel_i) ? "R5" : "R3";
            tag_rx = (!rx_t2_sel_i) ? "R5" : "R4";
        end
        m_pmode = mode_i;
    endtask

    // One clock: model, let the edge pass, compare at the falling edge.
    task automatic step();
        model_edge();
        @(negedge clk);
        chk(tx_tick_o, e_tx, tag_tx);
        chk(rx_tick_o, e_rx, tag_rx);
        vecs++;
        if ((tx_tick_o && prev_tx) || (rx_tick_o && prev_rx)) begin
            miss++;
            $display("FAIL R6: actual=consecutive ticks expected=single pulse");
        end
        if (m_fixed) chk(tx_tick_o, rx_tick_o, "R9");
        prev_tx = tx_tick_o;
        prev_rx = rx_tick_o;
    endtask

    // Overflow pulse patterns for the sweep.
    task automatic set_pulses(input int pat, input int k);
        case (pat)
            0: begin t1_ovf_i = 1'b1;               t2_ovf_i = ((k % 3) == 0); end
            1: begin t1_ovf_i = ($urandom_range(0, 3) == 0); t2_ovf_i = ($urandom_range(0, 1) == 0); end
            default: begin t1_ovf_i = ((k % 2) == 0); t2_ovf_i = ((k % 2) == 0); end
        endcase
    endtask

    initial begin
        rst_n = 1'b0; mode_i = 2'b00; dbl_i = 1'b0;
        tx_t2_sel_i = 1'b0; rx_t2_sel_i = 1'b0; t1_ovf_i = 1'b0; t2_ovf_i = 1'b0;
        m_pmode = 2'b00; prev_tx = 1'b0; prev_rx = 1'b0;
        @(negedge clk);
        // Reset state with pulses active (R8)
        t1_ovf_i = 1'b1; t2_ovf_i = 1'b1;
        for (int i = 0; i < 4; i++) step();

        // Sweep: every mode, doubling, source pair and pulse pattern (R1-R5, R6, R9)
        for (int m = 0; m < 4; m++)
            for (int d = 0; d < 2; d++)
                for (int s = 0; s < 4; s++)
                    for (int p = 0; p < 3; p++) begin
                        rst_n = 1'b0;
                        mode_i = 2'(m); dbl_i = d[0];
                        tx_t2_sel_i = s[0]; rx_t2_sel_i = s[1];
                        step(); step();
                        rst_n = 1'b1;
                        for (int k = 0; k < 260; k++) begin
                            set_pulses(p, k);
                            step();
                        end
                    end

        // Mode switching with pulses landing on the switch edges (R7)
        rst_n = 1'b0; mode_i = 2'b01; dbl_i = 1'b0;
        tx_t2_sel_i = 1'b0; rx_t2_sel_i = 1'b1;
        step();
        rst_n = 1'b1;
        for (int seg = 0; seg < 16; seg++) begin
            case (seg % 8)
                0: mode_i = 2'b01; 1: mode_i = 2'b11; 2: mode_i = 2'b00; 3: mode_i = 2'b10;
                4: mode_i = 2'b11; 5: mode_i = 2'b01; 6: mode_i = 2'b10; default: mode_i = 2'b00;
            endcase
            for (int k = 0; k < 37; k++) begin
                t1_ovf_i = 1'b1;
                t2_ovf_i = ((k % 2) == 0);
                if (k == 20) dbl_i = ~dbl_i;
                if (k == 25) tx_t2_sel_i = ~tx_t2_sel_i;
                step();
            end
        end

        summary();
        $finish;
    end

endmodule